// File: doc/BRIEF.md
# Prescaled Timer/Counter with Snapshot Capture

This block is a free-running up-counter with a programmable divider in front of it and a bank of snapshot registers beside it. In timer mode a prescale stage counts system clocks and the main counter advances once each time the prescale stage wraps. Software can therefore trade count resolution against how long the counter runs before it overflows. In counter mode the prescale stage is parked at zero. The main counter then advances on the chosen transitions of one of the external capture inputs, which turns the block into an event counter.

Each capture input is brought into the clock domain by a two-flop synchronizer. An edge detector then watches the synchronized signal. Every channel has its own rising and falling enables. When a selected transition appears, the channel copies the main counter into its snapshot register and, if its interrupt enable is set, raises a sticky flag. The flag is cleared by writing a one to it. The capture channels keep working in both count modes, and they keep working while counting is paused.

Top module: `cap_timer`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the counter, the prescale counter, every capture register and every interrupt flag read zero.
- R2: In timer mode with counting enabled, the prescale counter rises by one every clock. When it equals the programmed limit it wraps to zero in the next clock, and in that same clock the main counter rises by one. One count therefore takes limit+1 clocks.
- R3: With the enable low and no counter reset, neither the main counter nor the prescale counter changes.
- R4: The synchronous counter reset forces both the main counter and the prescale counter to zero on the next clock and holds them there while it is high. It takes priority over the enable.
- R5: In counter mode the prescale counter stays at zero. The main counter rises by one for each selected transition of the synchronized capture input picked by the source select. The edge select encodes 00 as none, 01 as rising, 10 as falling and 11 as both. A source select of 3 or above picks no input.
- R6: A transition on a capture input updates the matching capture register on the third rising clock edge after the input changes. The value stored is the main counter value held just before that edge.
- R7: Each channel captures on a rising transition when its rising enable is set and on a falling transition when its falling enable is set, so either transition captures when both are set. A channel with both enables clear keeps its register unchanged.
- R8: Capture channels operate in timer and counter mode alike and while counting is disabled. In counter mode a capture and a count caused by the same transition store the count from before the increment.
- R9: A capture sets the channel's interrupt flag only when that channel's interrupt enable is high. With the enable low, the capture register still updates and the flag stays low.
- R10: Interrupt flags are sticky until a one is written to the matching clear bit. If a new capture event and a clear arrive in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| cnt_rst_i | input | 1 | Synchronous clear of main and prescale counters |
| cnt_mode_i | input | 1 | 0 timer mode, 1 counter mode |
| cnt_src_i | input | 2 | Capture input that clocks the counter in counter mode |
| cnt_edge_i | input | 2 | Counter-mode edge select (00 none, 01 rise, 10 fall, 11 both) |
| presc_max_i | input | 32 | Prescale wrap limit |
| cap_in_i | input | 3 | Asynchronous capture inputs |
| cap_rise_en_i | input | 3 | Per-channel rising-edge capture enable |
| cap_fall_en_i | input | 3 | Per-channel falling-edge capture enable |
| cap_irq_en_i | input | 3 | Per-channel interrupt enable |
| irq_clr_i | input | 3 | Write-one clear of the interrupt flags |
| count_o | output | 32 | Main counter value |
| presc_o | output | 32 | Prescale counter value |
| cap_val_o | output | 3x32 | Capture registers, one per channel |
| irq_o | output | 3 | Sticky interrupt flags |

## Verification
The hardest case to reach from the ports is a capture event landing in the same clock as a write-one clear of the same flag. The edge reaches the flag only after the synchronizer and detector stages. The bench drives the capture input on a falling clock edge, counts out the two stages, and raises the clear on exactly the falling edge before the capture clock. Capture latency is checked the same way against a counter that runs every clock. This pins down both the stored value and the cycle in which it appears.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } cnt_mode_e;

endpackage

// File: rtl/ct_cap_sync.sv
module ct_cap_sync #(
    parameter int NCAP = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NCAP-1:0] raw_i,
    output logic [NCAP-1:0] rise_o,
    output logic [NCAP-1:0] fall_o
);
    typedef struct packed {
        logic [NCAP-1:0] meta;
        logic [NCAP-1:0] stable;
        logic [NCAP-1:0] last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = raw_i;
        s_d.stable = s_q.meta;
        s_d.last   = s_q.stable;
        rise_o     = s_q.stable & ~s_q.last;
        fall_o     = ~s_q.stable & s_q.last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int PW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic          bypass_i,
    input  logic [PW-1:0] max_i,
    output logic [PW-1:0] cnt_o,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        tick_o = 1'b0;
        if (clr_i || bypass_i) begin
            p_d.cnt = '0;
        end else if (en_i) begin
            if (p_q.cnt == max_i) begin
                p_d.cnt = '0;
                tick_o  = 1'b1;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end
        cnt_o = p_q.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end
endmodule

// File: rtl/ct_capture_chan.sv
module ct_capture_chan #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         rise_en_i,
    input  logic         fall_en_i,
    input  logic         irq_en_i,
    input  logic         clr_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] val_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         flag;
    } chan_t;

    chan_t c_d, c_q;
    logic  hit;

    always_comb begin
        c_d = c_q;
        hit = (rise_i & rise_en_i) | (fall_i & fall_en_i);
        if (hit) c_d.val = count_i;
        // an arriving event outranks a clear in the same cycle
        c_d.flag = (c_q.flag & ~clr_i) | (hit & irq_en_i);
        val_o    = c_q.val;
        flag_o   = c_q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter  int W     = 32,
    parameter  int PW    = 32,
    parameter  int NCAP  = 3,
    localparam int SRC_W = (NCAP > 1) ? $clog2(NCAP + 1) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     en_i,
    input  logic                     cnt_rst_i,
    input  logic                     cnt_mode_i,
    input  logic [SRC_W-1:0]         cnt_src_i,
    input  logic [1:0]               cnt_edge_i,
    input  logic [PW-1:0]            presc_max_i,
    input  logic [NCAP-1:0]          cap_in_i,
    input  logic [NCAP-1:0]          cap_rise_en_i,
    input  logic [NCAP-1:0]          cap_fall_en_i,
    input  logic [NCAP-1:0]          cap_irq_en_i,
    input  logic [NCAP-1:0]          irq_clr_i,
    output logic [W-1:0]             count_o,
    output logic [PW-1:0]            presc_o,
    output logic [NCAP-1:0][W-1:0]   cap_val_o,
    output logic [NCAP-1:0]          irq_o
);
    typedef struct packed {
        logic [W-1:0] count;
    } top_t;

    top_t            t_d, t_q;
    cnt_mode_e       mode;
    edge_sel_e       edge_sel;
    logic [NCAP-1:0] rise, fall;
    logic            tick, src_rise, src_fall, ext_hit;

    assign mode     = cnt_mode_e'(cnt_mode_i);
    assign edge_sel = edge_sel_e'(cnt_edge_i);

    ct_cap_sync #(.NCAP(NCAP)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (cap_in_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    ct_prescaler #(.PW(PW)) i_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .clr_i    (cnt_rst_i),
        .bypass_i (mode == MODE_COUNTER),
        .max_i    (presc_max_i),
        .cnt_o    (presc_o),
        .tick_o   (tick)
    );

    for (genvar g = 0; g < NCAP; g++) begin : g_chan
        ct_capture_chan #(.W(W)) i_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .rise_i    (rise[g]),
            .fall_i    (fall[g]),
            .rise_en_i (cap_rise_en_i[g]),
            .fall_en_i (cap_fall_en_i[g]),
            .irq_en_i  (cap_irq_en_i[g]),
            .clr_i     (irq_clr_i[g]),
            .count_i   (t_q.count),
            .val_o     (cap_val_o[g]),
            .flag_o    (irq_o[g])
        );
    end

    always_comb begin
        src_rise = 1'b0;
        src_fall = 1'b0;
        for (int i = 0; i < NCAP; i++) begin
            if (cnt_src_i == SRC_W'(i)) begin
                src_rise = rise[i];
                src_fall = fall[i];
            end
        end
        unique case (edge_sel)
            EDGE_RISE: ext_hit = src_rise;
            EDGE_FALL: ext_hit = src_fall;
            EDGE_BOTH: ext_hit = src_rise | src_fall;
            default:   ext_hit = 1'b0;
        endcase

        t_d = t_q;
        if (cnt_rst_i) begin
            t_d.count = '0;
        end else if (en_i) begin
            if ((mode == MODE_TIMER && tick) || (mode == MODE_COUNTER && ext_hit))
                t_d.count = t_q.count + 1'b1;
        end
        count_o = t_q.count;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
    parameter  int W     = 32,
    parameter  int PW    = 32,
    parameter  int NCAP  = 3,
    localparam int SRC_W = (NCAP > 1) ? $clog2(NCAP + 1) : 1
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   en_i,
    input logic                   cnt_rst_i,
    input logic                   cnt_mode_i,
    input logic [SRC_W-1:0]       cnt_src_i,
    input logic [PW-1:0]          presc_max_i,
    input logic [NCAP-1:0]        cap_rise_en_i,
    input logic [NCAP-1:0]        cap_fall_en_i,
    input logic [NCAP-1:0]        cap_irq_en_i,
    input logic [NCAP-1:0]        irq_clr_i,
    input logic [W-1:0]           count_o,
    input logic [PW-1:0]          presc_o,
    input logic [NCAP-1:0][W-1:0] cap_val_o,
    input logic [NCAP-1:0]        irq_o
);
    a_r4_cnt_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_rst_i |=> (count_o == '0 && presc_o == '0));

    a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !cnt_rst_i) |=> ($stable(count_o) && $stable(presc_o)));

    a_r2_presc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !cnt_rst_i && !cnt_mode_i && presc_o < presc_max_i)
        |=> (count_o == $past(count_o) && presc_o == $past(presc_o) + 1'b1));

    a_r5_presc_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_mode_i |=> presc_o == '0);

    a_r5_bad_src_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_mode_i && !cnt_rst_i && int'(cnt_src_i) >= NCAP) |=> $stable(count_o));

    for (genvar i = 0; i < NCAP; i++) begin : g_ch
        a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o[i] && !irq_clr_i[i]) |=> irq_o[i]);

        a_r9_no_flag_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!irq_o[i] && !cap_irq_en_i[i]) |=> !irq_o[i]);

        a_r7_no_capture_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!cap_rise_en_i[i] && !cap_fall_en_i[i]) |=> $stable(cap_val_o[i]));
    end
endmodule

bind cap_timer cap_timer_chk #(.W(W), .PW(PW), .NCAP(NCAP)) i_cap_timer_chk (.*);

// File: tb/test_cap_timer.sv
module test_cap_timer;
    localparam int W = 32;
    localparam int PW = 32;
    localparam int NC = 3;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              en_i = 1'b0;
    logic              cnt_rst_i = 1'b0;
    logic              cnt_mode_i = 1'b0;
    logic [1:0]        cnt_src_i = '0;
    logic [1:0]        cnt_edge_i = '0;
    logic [PW-1:0]     presc_max_i = '0;
    logic [NC-1:0]     cap_in_i = '0;
    logic [NC-1:0]     cap_rise_en_i = '0;
    logic [NC-1:0]     cap_fall_en_i = '0;
    logic [NC-1:0]     cap_irq_en_i = '0;
    logic [NC-1:0]     irq_clr_i = '0;
    logic [W-1:0]      count_o;
    logic [PW-1:0]     presc_o;
    logic [NC-1:0][W-1:0] cap_val_o;
    logic [NC-1:0]     irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    cap_timer i_cap_timer (.*);

    localparam int unsigned NV = 6;
    localparam int unsigned VP[NV] = '{0, 1, 2, 4, 6, 9};
    localparam int unsigned VN[NV] = '{10, 11, 15, 23, 7, 40};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic clear_counter;
        cnt_rst_i = 1'b1;
        step(1);
        cnt_rst_i = 1'b0;
    endtask

    task automatic run_counter_mode(input logic [1:0] src, input logic [1:0] edg,
                                    input logic [W-1:0] exp, input string req);
        en_i = 1'b0;
        cnt_mode_i = 1'b1;
        cnt_src_i = src;
        cnt_edge_i = edg;
        clear_counter();
        en_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cap_in_i[1] = 1'b1;
            step(3);
            cap_in_i[1] = 1'b0;
            step(3);
        end
        step(4);
        check(req, count_o, exp);
        check("R5 presc parked", presc_o, 0);
    endtask

    initial begin
        logic [W-1:0] c0;
        logic [W-1:0] hold;
        step(2);
        // R1: reset state
        check("R1 count", count_o, 0);
        check("R1 presc", presc_o, 0);
        check("R1 cap0", cap_val_o[0], 0);
        check("R1 irq", {29'd0, irq_o}, 0);
        rst_ni = 1'b1;
        step(1);

        // R2: vector table of prescale limit and enabled cycles
        for (int v = 0; v < NV; v++) begin
            en_i = 1'b0;
            presc_max_i = VP[v];
            clear_counter();
            en_i = 1'b1;
            step(VN[v]);
            en_i = 1'b0;
            check("R2 count", count_o, VN[v] / (VP[v] + 1));
            check("R2 presc", presc_o, VN[v] % (VP[v] + 1));
        end

        // R3: hold when disabled
        hold = count_o;
        step(5);
        check("R3 count hold", count_o, hold);
        check("R3 presc hold", presc_o, 40 % 10);

        // R4: counter reset beats enable and holds
        en_i = 1'b1;
        presc_max_i = 0;
        cnt_rst_i = 1'b1;
        step(5);
        check("R4 count zero", count_o, 0);
        check("R4 presc zero", presc_o, 0);
        cnt_rst_i = 1'b0;
        step(3);
        check("R4 resumes", count_o, 3);

        // R6: capture latency and value, counter running every clock
        cap_rise_en_i = 3'b001;
        cap_irq_en_i = 3'b011;
        c0 = count_o;
        cap_in_i[0] = 1'b1;
        step(2);
        check("R6 not yet captured", cap_val_o[0], 0);
        check("R6 no flag yet", {31'd0, irq_o[0]}, 0);
        step(1);
        check("R6 captured value", cap_val_o[0], c0 + 2);
        check("R9 flag set", {31'd0, irq_o[0]}, 1);
        hold = cap_val_o[0];

        // R7: falling edge ignored when only rising enabled
        cap_in_i[0] = 1'b0;
        step(4);
        check("R7 fall ignored", cap_val_o[0], hold);

        // R10: sticky, then write-one clear
        step(3);
        check("R10 sticky", {31'd0, irq_o[0]}, 1);
        irq_clr_i[0] = 1'b1;
        step(1);
        irq_clr_i[0] = 1'b0;
        check("R10 cleared", {31'd0, irq_o[0]}, 0);

        // R10: set and clear in the same cycle, set wins
        cap_in_i[0] = 1'b1;
        step(2);
        irq_clr_i[0] = 1'b1;
        step(1);
        irq_clr_i[0] = 1'b0;
        check("R10 set beats clear", {31'd0, irq_o[0]}, 1);
        irq_clr_i = 3'b111;
        step(1);
        irq_clr_i = '0;

        // R7: both enables on channel 1
        cap_rise_en_i[1] = 1'b1;
        cap_fall_en_i[1] = 1'b1;
        c0 = count_o;
        cap_in_i[1] = 1'b1;
        step(3);
        check("R7 both rise", cap_val_o[1], c0 + 2);
        c0 = count_o;
        cap_in_i[1] = 1'b0;
        step(3);
        check("R7 both fall", cap_val_o[1], c0 + 2);

        // R7: channel 2 with no enables
        cap_in_i[2] = 1'b1;
        step(4);
        cap_in_i[2] = 1'b0;
        step(4);
        check("R7 unarmed channel", cap_val_o[2], 0);

        // R9: capture without interrupt enable
        cap_rise_en_i[2] = 1'b1;
        c0 = count_o;
        cap_in_i[2] = 1'b1;
        step(3);
        check("R9 captured unarmed irq", cap_val_o[2], c0 + 2);
        check("R9 flag low", {31'd0, irq_o[2]}, 0);
        cap_in_i[2] = 1'b0;
        step(3);

        // R8: capture while counting is disabled
        en_i = 1'b0;
        hold = count_o;
        cap_in_i[0] = 1'b0;
        step(4);
        cap_in_i[0] = 1'b1;
        step(4);
        check("R8 capture while paused", cap_val_o[0], hold);
        cap_in_i[0] = 1'b0;
        step(3);

        // R5 / R8: counter mode from channel 1
        cap_fall_en_i[1] = 1'b0;
        run_counter_mode(2'd1, 2'b01, 4, "R5 rising count");
        check("R8 capture in counter mode", cap_val_o[1], 3);
        run_counter_mode(2'd1, 2'b10, 4, "R5 falling count");
        run_counter_mode(2'd1, 2'b11, 8, "R5 both count");
        run_counter_mode(2'd1, 2'b00, 0, "R5 no edge");
        run_counter_mode(2'd3, 2'b11, 0, "R5 invalid source");
        run_counter_mode(2'd0, 2'b11, 0, "R5 other source");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule